// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers a large set of peripheral interrupt requests, organised as groups of equal width (twelve groups of eight by default), and folds each group onto a single interrupt line toward the processor. Every input owns a sticky flag bit that is set when the input requests. Each group has its own enable byte and one acknowledge bit. A single global enable sits in front of all group lines.

A group line pulses for one clock when three conditions hold: the global enable is on, the group's acknowledge bit is clear, and at least one of its flags is set with the matching enable bit. In the same cycle the hardware sets that group's acknowledge bit. No further pulse leaves the group until software clears the bit by writing 1 to it. When the processor fetches the vector of a group, the block returns the table position of the lowest-numbered input in that group that is both flagged and enabled. That position is the group index times the group width plus the input index. The block clears that flag in the same step. Configuration arrives through plain write strobes.

Top module: `grp_irq_expander`

## Requirements
- R1: After synchronous reset, `cpu_irq`, `ack_busy` and `vec_valid` are all 0, every enable bit is 0, the global enable is 0 and every flag is clear.
- R2: An input at 1 during a clock edge sets its flag bit, whatever the state of the enables and the acknowledge bits. The flag stays set until a vector fetch clears it.
- R3: When group g has some flag set with its enable bit at 1, and the global enable is 1 and `ack_busy[g]` is 0, `cpu_irq[g]` is 1 for exactly one cycle. That cycle starts on the edge after the flag was set.
- R4: While the global enable is 0, no `cpu_irq` bit goes to 1. Flags that were latched while it was 0 raise their group line once `glb_wdata`=1 is written with `glb_wr`.
- R5: An enable bit at 0 keeps its input from raising the group line and from winning a fetch. The flag stays latched. Writing `en_wdata` with `en_wr[g]` replaces all enable bits of group g.
- R6: `ack_busy[g]` becomes 1 on the same edge on which `cpu_irq[g]` becomes 1. While it is 1, new requests to group g do not pulse `cpu_irq[g]`.
- R7: A write with `ack_wr` clears each `ack_busy` bit where `ack_wdata` holds 1 and leaves the bits where it holds 0. After the clear, any pending enabled flag in that group raises its line again.
- R8: A fetch (`fetch_req`=1 with group index `fetch_grp`) gives `vec_valid`=1 on the next cycle, with `vec_addr` = `fetch_grp`*8 + i. Here i is the lowest input index that is both flagged and enabled. That flag is cleared.
- R9: A fetch of a group with no flagged and enabled input gives `vec_valid`=0 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NG*GW (96) | Request inputs; bit g*GW+i is input i of group g |
| glb_wr | input | 1 | Write strobe for the global enable |
| glb_wdata | input | 1 | Global enable value (1 = on) |
| en_wr | input | NG (12) | Per-group enable write strobes |
| en_wdata | input | GW (8) | Enable byte written to each strobed group |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_wdata | input | NG (12) | Bit g = 1 clears the acknowledge bit of group g |
| fetch_req | input | 1 | Vector fetch strobe |
| fetch_grp | input | GIW (4) | Group index being fetched, counted from 0 |
| cpu_irq | output | NG (12) | Registered group interrupt lines |
| ack_busy | output | NG (12) | Acknowledge bits (1 = group waiting for acknowledge) |
| vec_valid | output | 1 | The last fetch found a source |
| vec_addr | output | VW (7) | Table position of the serviced source |

## Verification
The checker watches a few properties on every cycle. A group line never stays high for two cycles running, and it never fires while its acknowledge bit was already set. No line rises unless the global enable was on. Every line that fires has its acknowledge bit set. A valid vector always follows a fetch and stays within the table. Some behaviours only the bench scenarios can show: the lowest-index choice within a group, the exact vector values, flags that survive while masked or blocked, and the effect of acknowledge writes bit by bit. The bench reaches these through sequences of requests, fetches and acknowledges.

// File: rtl/gie_pkg.sv
package gie_pkg;

  // Index of the lowest set bit among the low n bits of v; 0 if none.
  function automatic int first_set(input logic [63:0] v, input int n);
    int r;
    bit found;
    r = 0;
    found = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (!found && i < n && v[i]) begin
        r = i;
        found = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/gie_group_slice.sv
module gie_group_slice #(
  parameter int GW = 8,
  localparam int IW = (GW > 1) ? $clog2(GW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] req,
  input  logic          glb_en,
  input  logic          en_we,
  input  logic [GW-1:0] en_wd,
  input  logic          ack_clr,
  input  logic          fetch_sel,
  output logic          irq_o,
  output logic          ack_o,
  output logic          pick_hit,
  output logic [IW-1:0] pick_idx
);
  import gie_pkg::*;

  logic [GW-1:0] flag_q;
  logic [GW-1:0] en_q;
  logic [GW-1:0] pend;
  logic [GW-1:0] clr_mask;
  logic          raise_c;

  assign pend     = flag_q & en_q;
  assign pick_hit = |pend;
  assign pick_idx = IW'(first_set(64'(pend), GW));
  assign raise_c  = glb_en && !ack_o && pick_hit;

  always_comb begin
    clr_mask = '0;
    if (fetch_sel && pick_hit) clr_mask[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      // a new request wins over a clear in the same cycle
      flag_q <= (flag_q & ~clr_mask) | req;
      if (en_we) en_q <= en_wd;
      if (raise_c)      ack_o <= 1'b1;
      else if (ack_clr) ack_o <= 1'b0;
      irq_o <= raise_c;
    end
  end

endmodule

// File: rtl/gie_vector_unit.sv
module gie_vector_unit #(
  parameter int NG = 12,
  parameter int GW = 8,
  localparam int GIW = (NG > 1) ? $clog2(NG) : 1,
  localparam int IW  = (GW > 1) ? $clog2(GW) : 1,
  localparam int VW  = $clog2(NG * GW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG-1:0]    hit,
  input  logic [NG*IW-1:0] idx_flat,
  input  logic             fetch_req,
  input  logic [GIW-1:0]   fetch_grp,
  output logic [NG-1:0]    fetch_sel,
  output logic             vec_valid,
  output logic [VW-1:0]    vec_addr
);

  logic          sel_hit;
  logic [IW-1:0] sel_idx;
  logic [VW-1:0] sel_addr;

  always_comb begin
    sel_hit   = 1'b0;
    sel_idx   = '0;
    fetch_sel = '0;
    for (int g = 0; g < NG; g++) begin
      if (fetch_grp == GIW'(g)) begin
        sel_hit      = hit[g];
        sel_idx      = idx_flat[g*IW +: IW];
        fetch_sel[g] = fetch_req;
      end
    end
  end

  assign sel_addr = VW'(fetch_grp) * VW'(GW) + VW'(sel_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else if (fetch_req) begin
      vec_valid <= sel_hit;
      if (sel_hit) vec_addr <= sel_addr;
    end else begin
      vec_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander #(
  parameter int NG = 12,
  parameter int GW = 8,
  localparam int GIW = (NG > 1) ? $clog2(NG) : 1,
  localparam int IW  = (GW > 1) ? $clog2(GW) : 1,
  localparam int VW  = $clog2(NG * GW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG*GW-1:0] irq_req,
  input  logic             glb_wr,
  input  logic             glb_wdata,
  input  logic [NG-1:0]    en_wr,
  input  logic [GW-1:0]    en_wdata,
  input  logic             ack_wr,
  input  logic [NG-1:0]    ack_wdata,
  input  logic             fetch_req,
  input  logic [GIW-1:0]   fetch_grp,
  output logic [NG-1:0]    cpu_irq,
  output logic [NG-1:0]    ack_busy,
  output logic             vec_valid,
  output logic [VW-1:0]    vec_addr
);

  logic             glb_en_q;
  logic [NG-1:0]    hit;
  logic [NG*IW-1:0] idx_flat;
  logic [NG-1:0]    fetch_sel;

  always_ff @(posedge clk) begin
    if (rst)         glb_en_q <= 1'b0;
    else if (glb_wr) glb_en_q <= glb_wdata;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    gie_group_slice #(.GW(GW)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .req       (irq_req[g*GW +: GW]),
      .glb_en    (glb_en_q),
      .en_we     (en_wr[g]),
      .en_wd     (en_wdata),
      .ack_clr   (ack_wr && ack_wdata[g]),
      .fetch_sel (fetch_sel[g]),
      .irq_o     (cpu_irq[g]),
      .ack_o     (ack_busy[g]),
      .pick_hit  (hit[g]),
      .pick_idx  (idx_flat[g*IW +: IW])
    );
  end

  gie_vector_unit #(.NG(NG), .GW(GW)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .idx_flat  (idx_flat),
    .fetch_req (fetch_req),
    .fetch_grp (fetch_grp),
    .fetch_sel (fetch_sel),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr)
  );

endmodule

// File: rtl/gie_checker.sv
module gie_checker #(
  parameter int NG = 12,
  parameter int GW = 8,
  parameter int VW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [NG-1:0] cpu_irq,
  input logic [NG-1:0] ack_busy,
  input logic          vec_valid,
  input logic [VW-1:0] vec_addr,
  input logic          fetch_req,
  input logic          glb_en_q
);

  // R3
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq & $past(cpu_irq)) == '0);

  // R6
  ack_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq & $past(ack_busy)) == '0);

  // R6
  irq_sets_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq & ~ack_busy) == '0);

  // R4
  glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (|cpu_irq) |-> $past(glb_en_q));

  // R8
  vec_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(fetch_req));

  // R8
  vec_in_table_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (int'(vec_addr) < NG * GW));

endmodule

bind grp_irq_expander gie_checker #(.NG(NG), .GW(GW), .VW(VW)) u_chk (.*);

// File: tb/tb_grp_irq_expander.sv
module tb_grp_irq_expander;
  localparam int NG = 12, GW = 8, GIW = 4, VW = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic [NG*GW-1:0] irq_req = '0;
  logic glb_wr = 0, glb_wdata = 0, ack_wr = 0, fetch_req = 0;
  logic [NG-1:0] en_wr = '0, ack_wdata = '0;
  logic [GW-1:0] en_wdata = '0;
  logic [GIW-1:0] fetch_grp = '0;
  logic [NG-1:0] cpu_irq, ack_busy;
  logic vec_valid;
  logic [VW-1:0] vec_addr;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  grp_irq_expander dut (.*);

  typedef struct packed {
    logic [3:0] grp; logic [7:0] req; logic [7:0] en; logic fire; logic [6:0] vec;
  } vec_t;
  localparam vec_t TBL [6] = '{
    '{4'd0,  8'h01, 8'hFF, 1'b1, 7'd0},
    '{4'd3,  8'h0C, 8'hFF, 1'b1, 7'd26},
    '{4'd11, 8'h80, 8'hFF, 1'b1, 7'd95},
    '{4'd5,  8'hF0, 8'h30, 1'b1, 7'd44},
    '{4'd7,  8'h0F, 8'hF0, 1'b0, 7'd0},
    '{4'd2,  8'hA0, 8'hA0, 1'b1, 7'd21}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic set_glb(input logic v);
    glb_wr = 1; glb_wdata = v; tick(); glb_wr = 0;
  endtask

  task automatic set_en(input int g, input logic [7:0] m);
    en_wr = '0; en_wr[g] = 1'b1; en_wdata = m; tick(); en_wr = '0;
  endtask

  task automatic pulse_req(input int g, input logic [7:0] m);
    irq_req[g*GW +: GW] = m; tick(); irq_req = '0;
  endtask

  task automatic write_ack(input logic [NG-1:0] m);
    ack_wr = 1; ack_wdata = m; tick(); ack_wr = 0; ack_wdata = '0;
  endtask

  task automatic fetch(input int g);
    fetch_req = 1; fetch_grp = GIW'(g); tick(); fetch_req = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(cpu_irq == '0, "R1 cpu_irq", cpu_irq, 0);
    chk(ack_busy == '0, "R1 ack_busy", ack_busy, 0);
    chk(vec_valid == 1'b0, "R1 vec_valid", vec_valid, 0);

    // table walk: R3 R5 R8 R9
    foreach (TBL[k]) begin
      do_reset();
      set_glb(1'b1);
      set_en(TBL[k].grp, TBL[k].en);
      pulse_req(TBL[k].grp, TBL[k].req);
      chk(cpu_irq == '0, "R3 no early pulse", cpu_irq, 0);
      tick();
      chk(cpu_irq == (TBL[k].fire ? (NG'(1) << TBL[k].grp) : NG'(0)), "R3/R5 line",
          cpu_irq, TBL[k].fire ? (1 << TBL[k].grp) : 0);
      tick();
      chk(cpu_irq == '0, "R3 one-cycle pulse", cpu_irq, 0);
      fetch(TBL[k].grp);
      chk(vec_valid == TBL[k].fire, "R8/R9 vec_valid", vec_valid, TBL[k].fire);
      if (TBL[k].fire)
        chk(vec_addr == TBL[k].vec, "R8 vec_addr", vec_addr, TBL[k].vec);
    end

    // R4: global off blocks, latched flag raises when enabled
    do_reset();
    set_en(1, 8'hFF);
    pulse_req(1, 8'h01);
    tick(); tick();
    chk(cpu_irq == '0, "R4 global off", cpu_irq, 0);
    set_glb(1'b1);
    chk(cpu_irq == '0, "R4 not yet", cpu_irq, 0);
    tick();
    chk(cpu_irq[1] == 1'b1, "R4/R2 latched raise", cpu_irq[1], 1);
    chk(ack_busy[1] == 1'b1, "R6 ack set", ack_busy[1], 1);

    // R6: further requests held back
    pulse_req(1, 8'h08);
    tick(); tick();
    chk(cpu_irq[1] == 1'b0, "R6 blocked", cpu_irq[1], 0);
    // R7: writing 0 leaves the bit
    write_ack('0);
    tick();
    chk(ack_busy[1] == 1'b1, "R7 zero write ignored", ack_busy[1], 1);
    chk(cpu_irq[1] == 1'b0, "R7 still blocked", cpu_irq[1], 0);
    // R7: writing 1 clears and re-raises
    write_ack(NG'(1) << 1);
    chk(ack_busy[1] == 1'b0, "R7 cleared", ack_busy[1], 0);
    tick();
    chk(cpu_irq[1] == 1'b1, "R7 re-raise", cpu_irq[1], 1);

    // R8 ordering, then R9 empty
    do_reset();
    set_en(4, 8'hFF);
    pulse_req(4, 8'h29);
    fetch(4);
    chk(vec_valid && vec_addr == 7'd32, "R8 first", vec_addr, 32);
    fetch(4);
    chk(vec_valid && vec_addr == 7'd35, "R8 second", vec_addr, 35);
    fetch(4);
    chk(vec_valid && vec_addr == 7'd37, "R8 third", vec_addr, 37);
    fetch(4);
    chk(vec_valid == 1'b0, "R9 drained", vec_valid, 0);

    // R5: masked input keeps its flag
    do_reset();
    set_glb(1'b1);
    pulse_req(6, 8'h01);
    tick(); tick();
    chk(cpu_irq == '0, "R5 masked", cpu_irq, 0);
    fetch(6);
    chk(vec_valid == 1'b0, "R5 masked fetch", vec_valid, 0);
    set_en(6, 8'h01);
    tick();
    chk(cpu_irq[6] == 1'b1, "R5/R2 unmask raise", cpu_irq[6], 1);
    fetch(6);
    chk(vec_valid && vec_addr == 7'd48, "R8 group 6", vec_addr, 48);

    summary();
    $finish;
  end
endmodule